// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block tracks the exception state of the instructions in flight in a five-stage in-order pipeline and resolves that state at one commit point, the end of the memory stage. Each instruction entering decode brings a valid bit, its PC and any fetch-address fault. The unit carries that information through the decode, execute and memory pipeline registers. The pipeline raises an illegal-opcode flag in decode, an overflow flag in execute and a data-address flag in memory, and each flag is folded into the travelling record. Faults are detected elsewhere; this unit only orders them and acts on them.

At commit the unit chooses among three outcomes. The instruction may write back normally. It may take a trap: the unit records a cause code and the instruction's PC, flushes every younger stage, suppresses the writeback and sends fetch to a fixed handler address. It may be a return-from-exception, which resumes at the saved PC. An enabled external interrupt is taken at commit in place of the instruction that sits there. The unit also holds the interrupt-enable bit and the kernel-mode bit that traps and returns switch.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset, `flush` and `wb_valid` are 0, `cause` and `epc` are 0, `kernel_mode` is 1 and `irq_en` is 0.
- R2: A fault-free instruction presented with `fetch_valid` in cycle t reaches commit in cycle t+3. In that cycle `wb_valid` is 1, `wb_pc` equals its PC and `flush` is 0.
- R3: An overflow flagged while the instruction is in execute makes its commit cycle show `flush`=1, `redirect_pc`=HANDLER_PC and `wb_valid`=0. From the next cycle `cause` reads 3 (arithmetic overflow) and `epc` holds that instruction's PC.
- R4: When one instruction carries several faults, the cause of the earliest stage is recorded. The codes are fetch-address fault 1, illegal opcode 2 and overflow 3.
- R5: A data-address fault flagged at commit is taken with cause 4, and the faulting PC goes to `epc`.
- R6: Instructions older than the trapping one commit normally. The instructions in decode and execute, and the one fetched in the trap's commit cycle, never assert `wb_valid`.
- R7: Taking a trap or an interrupt sets `kernel_mode` to 1 and `irq_en` to 0 from the next cycle.
- R8: A fault-free return-from-exception (flagged in decode) commits with `flush`=1 and `redirect_pc` equal to the current `epc`. From the next cycle `kernel_mode` is 0 and `irq_en` is 1.
- R9: `ext_irq` asserted while `irq_en`=1 and a valid instruction is at commit is taken with cause 0 (external interrupt). It overrides any internal fault of that instruction, and `epc` receives that instruction's PC.
- R10: `ext_irq` has no effect while `irq_en`=0, and none when the commit slot holds a bubble.
- R11: A bubble at commit never takes an internal exception: `mem_addr_fault` asserted then leaves `flush` at 0 and the mode bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction enters decode at the next edge |
| fetch_pc | input | PC_W | PC of the entering instruction |
| fetch_addr_fault | input | 1 | Fetch-address fault of the entering instruction |
| dec_illegal | input | 1 | Illegal opcode of the instruction in decode |
| dec_rfe | input | 1 | Instruction in decode is a return-from-exception |
| ex_overflow | input | 1 | Overflow of the instruction in execute |
| mem_addr_fault | input | 1 | Data-address fault of the instruction in memory |
| ext_irq | input | 1 | Pending external interrupt request |
| flush | output | 1 | Kill fetch, decode and execute; redirect fetch |
| redirect_pc | output | PC_W | Fetch target when `flush` is 1 |
| wb_valid | output | 1 | Instruction at commit writes back |
| wb_pc | output | PC_W | PC of the instruction at commit |
| cause | output | 3 | Recorded cause code |
| epc | output | PC_W | Saved PC of the trapped instruction |
| irq_en | output | 1 | Interrupt enable |
| kernel_mode | output | 1 | 1 = kernel mode, 0 = user mode |

## Verification
A clean instruction stream shows the three-cycle path from fetch to commit. Single faults in each of the three flagging stages show where each fault enters the record. Pairs of faults on one instruction separate earliest-stage priority from a last-writer-wins merge. An overflow with one older instruction and three younger ones separates a precise flush from one that kills too much or too little. Interrupts are tried with the interrupt enable set, with it cleared and with a bubble at commit, and a fault flag on a bubble shows that only valid instructions can trap.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int CAUSE_W = 3;
   localparam int NSTG    = 3;   // decode, execute, memory

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_IRQ     = 3'd0,
      CAUSE_FETCH   = 3'd1,
      CAUSE_ILLEGAL = 3'd2,
      CAUSE_OVF     = 3'd3,
      CAUSE_DADDR   = 3'd4
   } cause_e;

   typedef struct packed {
      logic   valid;
      logic   exc;
      cause_e cause;
      logic   rfe;
   } itag_t;

   // fault code raised inside a given pipeline register stage
   function automatic cause_e stage_cause(input int stg);
      case (stg)
         0:       return CAUSE_ILLEGAL;
         1:       return CAUSE_OVF;
         default: return CAUSE_DADDR;
      endcase
   endfunction

endpackage

// File: rtl/exc_pipe_stage.sv
module exc_pipe_stage
   import exc_pkg::*;
#(
   parameter int unsigned PC_W = 32,
   parameter int          STG  = 0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  itag_t           in_tag,
   input  logic [PC_W-1:0] in_pc,
   input  logic            flag,
   input  logic            rfe_in,
   output itag_t           out_tag,
   output logic [PC_W-1:0] out_pc
);

   itag_t           q_tag;
   logic [PC_W-1:0] q_pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_tag <= '0;
         q_pc  <= '0;
      end else if (flush) begin
         q_tag <= '0;
         q_pc  <= in_pc;
      end else begin
         q_tag <= in_tag;
         q_pc  <= in_pc;
      end
   end

   // a fault from an earlier stage keeps its code; a bubble never faults
   always_comb begin
      out_tag.valid = q_tag.valid;
      out_tag.exc   = q_tag.valid & (q_tag.exc | flag);
      out_tag.cause = q_tag.exc ? q_tag.cause : stage_cause(STG);
      out_tag.rfe   = q_tag.valid & (q_tag.rfe | rfe_in);
   end
   assign out_pc = q_pc;

   // R6: a flushed stage holds a bubble on the next cycle
   a_r6_flush_kills: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_tag.valid);

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
   import exc_pkg::*;
#(
   parameter int unsigned     PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = 'h80
)(
   input  logic            clk,
   input  logic            rst_n,
   input  itag_t           m_tag,
   input  logic [PC_W-1:0] m_pc,
   input  logic            ext_irq,
   output logic            flush,
   output logic [PC_W-1:0] redirect_pc,
   output logic            wb_valid,
   output logic [PC_W-1:0] wb_pc,
   output cause_e          cause,
   output logic [PC_W-1:0] epc,
   output logic            irq_en,
   output logic            kernel_mode
);

   logic take_irq, take_exc, take_rfe;

   assign take_irq = m_tag.valid & ext_irq & irq_en;
   assign take_exc = take_irq | m_tag.exc;
   assign take_rfe = m_tag.rfe & ~take_exc;

   assign flush       = take_exc | take_rfe;
   assign redirect_pc = take_exc ? HANDLER_PC : epc;
   assign wb_valid    = m_tag.valid & ~take_exc;
   assign wb_pc       = m_pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause       <= CAUSE_IRQ;
         epc         <= '0;
         irq_en      <= 1'b0;
         kernel_mode <= 1'b1;
      end else if (take_exc) begin
         cause       <= take_irq ? CAUSE_IRQ : m_tag.cause;
         epc         <= m_pc;
         irq_en      <= 1'b0;
         kernel_mode <= 1'b1;
      end else if (take_rfe) begin
         irq_en      <= 1'b1;
         kernel_mode <= 1'b0;
      end
   end

   a_r7_trap_enters_kernel: assert property (@(posedge clk) disable iff (!rst_n)
      take_exc |=> kernel_mode && !irq_en);

   a_r8_rfe_to_user: assert property (@(posedge clk) disable iff (!rst_n)
      take_rfe |=> !kernel_mode && irq_en);

   a_r3_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
      take_exc |=> epc == $past(m_pc));

   a_r11_bubble_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !m_tag.valid |-> !flush);

   a_r10_masked_irq_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && m_tag.valid && !m_tag.exc) |-> wb_valid);

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_pkg::*;
#(
   parameter int unsigned     PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = 'h80
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fetch_valid,
   input  logic [PC_W-1:0] fetch_pc,
   input  logic            fetch_addr_fault,
   input  logic            dec_illegal,
   input  logic            dec_rfe,
   input  logic            ex_overflow,
   input  logic            mem_addr_fault,
   input  logic            ext_irq,
   output logic            flush,
   output logic [PC_W-1:0] redirect_pc,
   output logic            wb_valid,
   output logic [PC_W-1:0] wb_pc,
   output logic [2:0]      cause,
   output logic [PC_W-1:0] epc,
   output logic            irq_en,
   output logic            kernel_mode
);

   localparam int LAST = NSTG - 1;

   if (PC_W < 8) begin : g_bad_width
      $error("exc_commit_unit: PC_W must be at least 8");
   end
   if (HANDLER_PC[1:0] != 2'b00) begin : g_bad_handler
      $error("exc_commit_unit: HANDLER_PC must be word aligned");
   end

   itag_t           tag_in  [NSTG];
   itag_t           tag_out [NSTG];
   logic [PC_W-1:0] pc_in   [NSTG];
   logic [PC_W-1:0] pc_out  [NSTG];
   logic [NSTG-1:0] flag_v;
   itag_t           fetch_tag;
   cause_e          cause_q;

   assign flag_v = {mem_addr_fault, ex_overflow, dec_illegal};

   always_comb begin
      fetch_tag.valid = fetch_valid;
      fetch_tag.exc   = fetch_valid & fetch_addr_fault;
      fetch_tag.cause = CAUSE_FETCH;
      fetch_tag.rfe   = 1'b0;
   end

   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      logic rfe_l;
      if (g == 0) begin : g_first
         assign tag_in[g] = fetch_tag;
         assign pc_in[g]  = fetch_pc;
         assign rfe_l     = dec_rfe;
      end else begin : g_next
         assign tag_in[g] = tag_out[g-1];
         assign pc_in[g]  = pc_out[g-1];
         assign rfe_l     = 1'b0;
      end
      exc_pipe_stage #(.PC_W(PC_W), .STG(g)) u_stg (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush),
         .in_tag  (tag_in[g]),
         .in_pc   (pc_in[g]),
         .flag    (flag_v[g]),
         .rfe_in  (rfe_l),
         .out_tag (tag_out[g]),
         .out_pc  (pc_out[g])
      );
   end

   exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .m_tag       (tag_out[LAST]),
      .m_pc        (pc_out[LAST]),
      .ext_irq     (ext_irq),
      .flush       (flush),
      .redirect_pc (redirect_pc),
      .wb_valid    (wb_valid),
      .wb_pc       (wb_pc),
      .cause       (cause_q),
      .epc         (epc),
      .irq_en      (irq_en),
      .kernel_mode (kernel_mode)
   );

   assign cause = cause_q;

endmodule

// File: tb/sim_exc_commit_unit.sv
`timescale 1ns/1ps
module sim_exc_commit_unit;

   localparam logic [31:0] H = 32'h80;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        fetch_valid, fetch_addr_fault, dec_illegal, dec_rfe;
   logic        ex_overflow, mem_addr_fault, ext_irq;
   logic [31:0] fetch_pc;
   logic        flush, wb_valid, irq_en, kernel_mode;
   logic [31:0] redirect_pc, wb_pc, epc;
   logic [2:0]  cause;

   int checks = 0;
   int fails  = 0;

   logic        s_fl, s_wbv, s_ien, s_kern;
   logic [31:0] s_rpc, s_wbpc, s_epc;
   logic [2:0]  s_cause;

   always #4 clk = ~clk;

   exc_commit_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .fetch_addr_fault(fetch_addr_fault), .dec_illegal(dec_illegal),
      .dec_rfe(dec_rfe), .ex_overflow(ex_overflow),
      .mem_addr_fault(mem_addr_fault), .ext_irq(ext_irq),
      .flush(flush), .redirect_pc(redirect_pc), .wb_valid(wb_valid),
      .wb_pc(wb_pc), .cause(cause), .epc(epc), .irq_en(irq_en),
      .kernel_mode(kernel_mode)
   );

   task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h exp %h", rq, got, exp);
      end
   endtask

   // one cycle: drive at the falling edge, sample shortly after
   task automatic cyc(input logic fv, input logic [31:0] fpc, input logic ffa,
                      input logic dill, input logic drfe, input logic eovf,
                      input logic mdf, input logic irq);
      @(negedge clk);
      fetch_valid = fv; fetch_pc = fpc; fetch_addr_fault = ffa;
      dec_illegal = dill; dec_rfe = drfe; ex_overflow = eovf;
      mem_addr_fault = mdf; ext_irq = irq;
      #1;
      s_fl = flush; s_rpc = redirect_pc; s_wbv = wb_valid; s_wbpc = wb_pc;
      s_cause = cause; s_epc = epc; s_ien = irq_en; s_kern = kernel_mode;
   endtask

   task automatic idle(input logic irq, input logic mdf);
      cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, mdf, irq);
   endtask

   // one instruction through decode, execute and commit
   task automatic single(input logic [31:0] pc, input logic ffa, input logic dill,
                         input logic drfe, input logic eovf, input logic mdf,
                         input logic irq);
      cyc(1'b1, pc, ffa, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 32'h0, 1'b0, dill, drfe, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, eovf, 1'b0, 1'b0);
      cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, mdf, irq);
   endtask

   task automatic t_reset();
      idle(1'b0, 1'b0);
      chk("R1 flush", {31'b0, s_fl}, 32'd0);
      chk("R1 wb_valid", {31'b0, s_wbv}, 32'd0);
      chk("R1 cause", {29'b0, s_cause}, 32'd0);
      chk("R1 epc", s_epc, 32'd0);
      chk("R1 kernel", {31'b0, s_kern}, 32'd1);
      chk("R1 irq_en", {31'b0, s_ien}, 32'd0);
   endtask

   task automatic t_clean();
      single(32'h100, 0, 0, 0, 0, 0, 0);
      chk("R2 wb_valid", {31'b0, s_wbv}, 32'd1);
      chk("R2 wb_pc", s_wbpc, 32'h100);
      chk("R2 flush", {31'b0, s_fl}, 32'd0);
   endtask

   task automatic t_rfe(input logic [31:0] pc, input logic [31:0] exp_epc);
      single(pc, 0, 0, 1, 0, 0, 0);
      chk("R8 flush", {31'b0, s_fl}, 32'd1);
      chk("R8 redirect", s_rpc, exp_epc);
      idle(1'b0, 1'b0);
      chk("R8 kernel", {31'b0, s_kern}, 32'd0);
      chk("R8 irq_en", {31'b0, s_ien}, 32'd1);
   endtask

   task automatic t_overflow();
      cyc(1, 32'h1FC, 0, 0, 0, 0, 0, 0);
      cyc(1, 32'h200, 0, 0, 0, 0, 0, 0);
      cyc(1, 32'h204, 0, 0, 0, 0, 0, 0);
      cyc(1, 32'h208, 0, 0, 0, 1, 0, 0);
      chk("R6 older commits", {31'b0, s_wbv}, 32'd1);
      chk("R6 older pc", s_wbpc, 32'h1FC);
      cyc(1, 32'h20C, 0, 0, 0, 0, 0, 0);
      chk("R3 flush", {31'b0, s_fl}, 32'd1);
      chk("R3 redirect", s_rpc, H);
      chk("R3 wb suppressed", {31'b0, s_wbv}, 32'd0);
      cyc(1, H, 0, 0, 0, 0, 0, 0);
      chk("R3 cause", {29'b0, s_cause}, 32'd3);
      chk("R3 epc", s_epc, 32'h200);
      chk("R7 kernel", {31'b0, s_kern}, 32'd1);
      chk("R7 irq_en", {31'b0, s_ien}, 32'd0);
      chk("R6 no wb c5", {31'b0, s_wbv}, 32'd0);
      idle(0, 0);
      chk("R6 no wb c6", {31'b0, s_wbv}, 32'd0);
      idle(0, 0);
      chk("R6 no wb c7", {31'b0, s_wbv}, 32'd0);
      idle(0, 0);
      chk("R6 handler commits", {31'b0, s_wbv}, 32'd1);
      chk("R6 handler pc", s_wbpc, H);
   endtask

   task automatic t_fault(input string rq, input logic [31:0] pc, input logic ffa,
                          input logic dill, input logic eovf, input logic mdf,
                          input logic [2:0] exp_cause);
      single(pc, ffa, dill, 0, eovf, mdf, 0);
      chk({rq, " redirect"}, s_rpc, H);
      chk({rq, " flush"}, {31'b0, s_fl}, 32'd1);
      idle(0, 0);
      chk({rq, " cause"}, {29'b0, s_cause}, {29'b0, exp_cause});
      chk({rq, " epc"}, s_epc, pc);
   endtask

   task automatic t_irq();
      single(32'h400, 0, 0, 0, 1, 0, 1);
      chk("R9 flush", {31'b0, s_fl}, 32'd1);
      chk("R9 wb suppressed", {31'b0, s_wbv}, 32'd0);
      idle(0, 0);
      chk("R9 cause", {29'b0, s_cause}, 32'd0);
      chk("R9 epc", s_epc, 32'h400);
      chk("R7 irq kernel", {31'b0, s_kern}, 32'd1);
      // interrupts now disabled: request must be ignored
      single(32'h500, 0, 0, 0, 0, 0, 1);
      chk("R10 masked flush", {31'b0, s_fl}, 32'd0);
      chk("R10 masked wb", {31'b0, s_wbv}, 32'd1);
      chk("R10 masked wb_pc", s_wbpc, 32'h500);
   endtask

   task automatic t_bubbles();
      idle(1, 0);
      chk("R10 bubble irq flush", {31'b0, s_fl}, 32'd0);
      idle(0, 0);
      chk("R10 bubble irq kernel", {31'b0, s_kern}, 32'd0);
      chk("R10 bubble irq en", {31'b0, s_ien}, 32'd1);
      idle(0, 1);
      chk("R11 bubble fault flush", {31'b0, s_fl}, 32'd0);
      idle(0, 0);
      chk("R11 bubble fault kernel", {31'b0, s_kern}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      fetch_valid = 0; fetch_pc = 0; fetch_addr_fault = 0; dec_illegal = 0;
      dec_rfe = 0; ex_overflow = 0; mem_addr_fault = 0; ext_irq = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_clean();
      t_rfe(32'h300, 32'h0);
      t_overflow();
      t_fault("R4 fetch+illegal", 32'h600, 1, 1, 0, 0, 3'd1);
      t_fault("R4 illegal+ovf",   32'h604, 0, 1, 1, 0, 3'd2);
      t_fault("R4 ovf+daddr",     32'h608, 0, 0, 1, 1, 3'd3);
      t_fault("R5 daddr",         32'h60C, 0, 0, 0, 1, 3'd4);
      t_rfe(32'h700, 32'h60C);
      t_irq();
      t_rfe(32'h704, 32'h400);
      t_bubbles();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule